// File: doc/BRIEF.md
# Serial-Port-Style Register Front End for a Character Display

This block lets software drive a character display terminal as if it were a classic asynchronous serial port. It decodes a two-byte window in an 8-bit peripheral address space. The low address holds a status register on reads and a control register on writes. The high address is a data port. A byte written to the data port is held in a one-entry holding register. It is offered to a downstream character sink over a valid/ready handshake.

No input device exists behind the block, so the receive side is inert. Its "data full" flag is always clear, and a data-port read returns zero. The modem-line status bits always report the active state: carrier present and clear to send. An interrupt request is raised when the transmit side can accept a byte and both interrupt enables in the control register are set. A control write with the reset code in its two low bits returns the interface to its post-reset state.

Top module: `acia_disp_regif`

## Requirements
- R1: The block responds only when address bits 7:1 equal `BASE_PAGE` (default 7'b0000011). Address bit 0 selects the register: 0 is status/control and 1 is data. Reads and writes at any other address leave every output and all internal state unchanged.
- R2: A status read places a byte on `rdData` one clock after the read strobe. Its layout is: bit 0 = receive full (always 0), bit 1 = transmit empty (1 = ready for a byte), bit 2 = carrier detect (always 0), bit 3 = clear to send (always 0), bits 6:4 = 0, bit 7 = interrupt request.
- R3: A data-port read places 8'h00 on `rdData` one clock after the read strobe.
- R4: A data-port write while the holding register is empty captures the byte. From the next clock, `sinkValid` is 1 with that byte on `sinkData`, and status bit 1 reads 0.
- R5: While `sinkValid` is 1 and `sinkReady` is 0, `sinkValid` stays 1 and `sinkData` stays stable. After a clock edge where both are 1, `sinkValid` is 0 and status bit 1 reads 1. Each written byte is delivered exactly once, in write order.
- R6: A data-port write that arrives while the holding register is full is dropped. This includes the cycle in which the sink accepts the held byte.
- R7: A control write stores bit 7 as the interrupt enable and bits 6:5 as the transmit control field. `irqReq` and status bit 7 equal the interrupt enable AND (transmit control == 2'b01) AND transmit-empty.
- R8: A control write with bits 1:0 = 2'b11 clears both control fields and empties the holding register. From the next clock, `sinkValid` and `irqReq` are 0 and status reads 8'h02.
- R9: After the asynchronous active-low reset, `sinkValid` = 0, `irqReq` = 0 and `rdData` = 0, and status reads 8'h02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periphAddr | input | ADDR_W | Peripheral address |
| periphWrN | input | 1 | Single-cycle active-low write strobe |
| periphRdN | input | 1 | Single-cycle active-low read strobe |
| periphWrData | input | DATA_W | Write data from the CPU |
| rdData | output | DATA_W | Registered read data |
| irqReq | output | 1 | Interrupt request, active high |
| sinkValid | output | 1 | Byte available for the character sink |
| sinkData | output | DATA_W | Byte offered to the sink |
| sinkReady | input | 1 | Sink accepts the offered byte |

## Verification
The bench builds the block with its default parameters: 8-bit address and data, and the window at page 7'b0000011 (addresses 0x06 and 0x07). These values put the neighbouring pages at 0x04/0x05 and 0x08 within reach. This lets the bench show that writes just outside the window leave the sink idle and the control state intact. With an 8-bit data path, every status bit position and every transmit control code can be exercised directly. Back-to-back data writes can also be placed on the exact cycle of a sink acceptance.

// File: rtl/acia_disp_pkg.sv
package acia_disp_pkg;

  typedef struct packed {
    logic loadData;
    logic masterReset;
    logic rdStatus;
    logic rdDataPort;
  } regStrobe_t;

  localparam int STAT_RX_FULL   = 0;
  localparam int STAT_TX_EMPTY  = 1;
  localparam int STAT_CARRIER   = 2;
  localparam int STAT_CLEAR_TX  = 3;
  localparam int STAT_IRQ       = 7;

  localparam int CTRL_IRQ_EN    = 7;
  localparam int CTRL_TXC_HI    = 6;
  localparam int CTRL_TXC_LO    = 5;

  localparam logic [1:0] CTRL_RESET_CODE = 2'b11;
  localparam logic [1:0] TXC_IRQ_ON      = 2'b01;

endpackage

// File: rtl/acia_disp_ctrl.sv
module acia_disp_ctrl
  import acia_disp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-2:0] BASE_PAGE = 7'b0000011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] periphAddr,
  input  logic              periphWrN,
  input  logic              periphRdN,
  input  logic [DATA_W-1:0] periphWrData,
  input  logic              txEmpty,
  output regStrobe_t        strobe,
  output logic              irqReq
);

  logic       pageHit;
  logic       regSel;
  logic       wrCycle;
  logic       rdCycle;
  logic       ctrlWrite;
  logic       resetCode;
  logic       irqEnR;
  logic [1:0] txCtlR;

  // Address decode: upper bits pick the page, bit 0 picks the register
  assign pageHit   = (periphAddr[ADDR_W-1:1] == BASE_PAGE);
  assign regSel    = periphAddr[0];
  assign wrCycle   = pageHit && !periphWrN;
  assign rdCycle   = pageHit && !periphRdN;
  assign ctrlWrite = wrCycle && !regSel;
  assign resetCode = (periphWrData[1:0] == CTRL_RESET_CODE);

  always_comb begin
    strobe             = '0;
    strobe.loadData    = wrCycle && regSel;
    strobe.masterReset = ctrlWrite && resetCode;
    strobe.rdStatus    = rdCycle && !regSel;
    strobe.rdDataPort  = rdCycle && regSel;
  end

  // Control register: interrupt enable and transmit control field
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnR <= 1'b0;
      txCtlR <= 2'b00;
    end else if (ctrlWrite && resetCode) begin
      irqEnR <= 1'b0;
      txCtlR <= 2'b00;
    end else if (ctrlWrite) begin
      irqEnR <= periphWrData[CTRL_IRQ_EN];
      txCtlR <= periphWrData[CTRL_TXC_HI:CTRL_TXC_LO];
    end
  end

  assign irqReq = irqEnR && (txCtlR == TXC_IRQ_ON) && txEmpty;

  // R8: the reset code leaves both enables cleared
  assert_mreset_clears_ctrl_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.masterReset |=> (!irqEnR && txCtlR == 2'b00));

  // R1: traffic outside the window leaves the control state untouched
  assert_outside_window_inert_R1: assert property (@(posedge clk) disable iff (!rstN)
    !pageHit |=> ($stable(irqEnR) && $stable(txCtlR)));

  // R7: the request never stands while the transmit side is busy
  assert_irq_needs_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> txEmpty);

  // Strobes are mutually exclusive per register
  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadData, strobe.masterReset}));

endmodule

// File: rtl/acia_disp_dp.sv
module acia_disp_dp
  import acia_disp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] periphWrData,
  input  logic              irqReq,
  input  logic              sinkReady,
  output logic              sinkValid,
  output logic [DATA_W-1:0] sinkData,
  output logic [DATA_W-1:0] rdData,
  output logic              txEmpty
);

  logic              holdFull;
  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] statusByte;
  logic              acceptNow;
  logic              captureNow;

  assign acceptNow  = holdFull && sinkReady;
  assign captureNow = strobe.loadData && !holdFull;

  // One-entry holding register toward the character sink
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdData <= '0;
    end else if (strobe.masterReset) begin
      holdFull <= 1'b0;
    end else if (captureNow) begin
      holdFull <= 1'b1;
      holdData <= periphWrData;
    end else if (acceptNow) begin
      holdFull <= 1'b0;
    end
  end

  assign sinkValid = holdFull;
  assign sinkData  = holdData;
  assign txEmpty   = !holdFull;

  // Status byte: receive side inert, modem lines report active (0)
  always_comb begin
    statusByte                = '0;
    statusByte[STAT_RX_FULL]  = 1'b0;
    statusByte[STAT_TX_EMPTY] = !holdFull;
    statusByte[STAT_CARRIER]  = 1'b0;
    statusByte[STAT_CLEAR_TX] = 1'b0;
    statusByte[STAT_IRQ]      = irqReq;
  end

  // Registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdStatus) begin
      rdData <= statusByte;
    end else if (strobe.rdDataPort) begin
      rdData <= '0;
    end
  end

  // R5: an offered byte is held until taken
  assert_hold_until_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinkValid && !sinkReady && !strobe.masterReset) |=> (sinkValid && $stable(sinkData)));

  // R6: a write into a full holding register does not disturb it
  assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && strobe.loadData) |=> $stable(holdData));

  // R4: a write into an empty holding register is offered next cycle
  assert_capture_offered_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!holdFull && strobe.loadData) |=> (sinkValid && sinkData == $past(periphWrData)));

  // R3: data-port reads return zero
  assert_data_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdDataPort |=> (rdData == '0));

  // R2: fixed status bits read zero
  assert_status_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdStatus |=> (rdData[STAT_RX_FULL] == 1'b0 && rdData[STAT_CARRIER] == 1'b0
                         && rdData[STAT_CLEAR_TX] == 1'b0));

  // R8: master reset empties the holding register
  assert_mreset_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.masterReset |=> !sinkValid);

endmodule

// File: rtl/acia_disp_regif.sv
module acia_disp_regif
  import acia_disp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-2:0] BASE_PAGE = 7'b0000011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] periphAddr,
  input  logic              periphWrN,
  input  logic              periphRdN,
  input  logic [DATA_W-1:0] periphWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq,
  output logic              sinkValid,
  output logic [DATA_W-1:0] sinkData,
  input  logic              sinkReady
);

  regStrobe_t strobe;
  logic       txEmpty;

  acia_disp_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_PAGE(BASE_PAGE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .periphAddr(periphAddr), .periphWrN(periphWrN),
    .periphRdN(periphRdN), .periphWrData(periphWrData), .txEmpty(txEmpty),
    .strobe(strobe), .irqReq(irqReq)
  );

  acia_disp_dp #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .periphWrData(periphWrData),
    .irqReq(irqReq), .sinkReady(sinkReady), .sinkValid(sinkValid),
    .sinkData(sinkData), .rdData(rdData), .txEmpty(txEmpty)
  );

  // R9: reset leaves the sink idle and the request low
  assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!sinkValid && !irqReq));

endmodule

// File: tb/acia_disp_regif_tb_top.sv
module acia_disp_regif_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] periphAddr = '0;
  logic       periphWrN = 1'b1;
  logic       periphRdN = 1'b1;
  logic [7:0] periphWrData = '0;
  logic [7:0] rdData;
  logic       irqReq;
  logic       sinkValid;
  logic [7:0] sinkData;
  logic       sinkReady = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expQ[$];
  logic done = 1'b0;

  localparam logic [7:0] ADDR_CTRL = 8'h06;
  localparam logic [7:0] ADDR_DATA = 8'h07;

  always #4 clk = ~clk;

  acia_disp_regif dut_i (
    .clk(clk), .rstN(rstN), .periphAddr(periphAddr), .periphWrN(periphWrN),
    .periphRdN(periphRdN), .periphWrData(periphWrData), .rdData(rdData),
    .irqReq(irqReq), .sinkValid(sinkValid), .sinkData(sinkData), .sinkReady(sinkReady)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    periphAddr = a; periphWrData = d; periphWrN = 1'b0;
    @(negedge clk);
    periphWrN = 1'b1;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    periphAddr = a; periphRdN = 1'b0;
    @(negedge clk);
    periphRdN = 1'b1;
    d = rdData;
  endtask

  task automatic sendByte(input logic [7:0] d);
    expQ.push_back(d);
    busWrite(ADDR_DATA, d);
  endtask

  // Monitor: pop expected bytes as the sink takes them
  always @(negedge clk) begin
    if (rstN && sinkValid && sinkReady) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R5: actual %h expected <none>", sinkData);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (sinkData !== e) begin
          nFails++;
          $display("FAIL R5: actual %h expected %h", sinkData, e);
        end
      end
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 sinkValid", {7'd0, sinkValid}, 8'h00);
    check("R9 irqReq", {7'd0, irqReq}, 8'h00);
    check("R9 rdData", rdData, 8'h00);
    busRead(ADDR_CTRL, r); check("R9 status", r, 8'h02);

    // R7 enable interrupt: bit7=1, txc=01
    busWrite(ADDR_CTRL, 8'hA0);
    check("R7 irq on", {7'd0, irqReq}, 8'h01);
    busRead(ADDR_CTRL, r); check("R2 status irq", r, 8'h82);

    // R4 write with sink stalled
    sendByte(8'h41);
    check("R4 sinkValid", {7'd0, sinkValid}, 8'h01);
    check("R4 sinkData", sinkData, 8'h41);
    check("R7 irq off busy", {7'd0, irqReq}, 8'h00);
    busRead(ADDR_CTRL, r); check("R4 status busy", r, 8'h00);

    // R6 write while full is dropped
    busWrite(ADDR_DATA, 8'h55);
    repeat (3) @(negedge clk);
    check("R6 sinkData kept", sinkData, 8'h41);
    check("R5 still valid", {7'd0, sinkValid}, 8'h01);

    // R5 release sink
    sinkReady = 1'b1;
    @(negedge clk);
    check("R5 drained", {7'd0, sinkValid}, 8'h00);
    busRead(ADDR_CTRL, r); check("R5 status empty", r, 8'h82);

    // R6 write on the acceptance edge is dropped
    sinkReady = 1'b0;
    sendByte(8'h10);
    sinkReady = 1'b1;
    busWrite(ADDR_DATA, 8'h99);
    @(negedge clk);
    check("R6 accept edge", {7'd0, sinkValid}, 8'h00);

    // R1 writes and reads outside the window
    busWrite(8'h05, 8'h03);
    busWrite(8'h04, 8'h00);
    busWrite(8'h08, 8'h5A);
    busWrite(8'h0F, 8'hC3);
    @(negedge clk);
    check("R1 no sink", {7'd0, sinkValid}, 8'h00);
    check("R1 irq kept", {7'd0, irqReq}, 8'h01);
    busRead(8'h09, r); check("R1 rd ignored", rdData, 8'h82);

    // R3 data read
    busRead(ADDR_DATA, r); check("R3 data read", r, 8'h00);

    // R7 transmit control codes
    busWrite(ADDR_CTRL, 8'hC0); check("R7 txc10", {7'd0, irqReq}, 8'h00);
    busWrite(ADDR_CTRL, 8'hE0); check("R7 txc11", {7'd0, irqReq}, 8'h00);
    busWrite(ADDR_CTRL, 8'h80); check("R7 txc00", {7'd0, irqReq}, 8'h00);
    busWrite(ADDR_CTRL, 8'h20); check("R7 no en", {7'd0, irqReq}, 8'h00);
    busWrite(ADDR_CTRL, 8'hA1); check("R7 en again", {7'd0, irqReq}, 8'h01);

    // R5 stream with ready high
    for (int i = 0; i < 6; i++) begin
      sendByte(8'h30 + 8'(i));
      @(negedge clk);
    end
    repeat (2) @(negedge clk);

    // R8 master reset with a byte held
    sinkReady = 1'b0;
    busWrite(ADDR_DATA, 8'h77);
    check("R8 pre valid", {7'd0, sinkValid}, 8'h01);
    busWrite(ADDR_CTRL, 8'h03);
    check("R8 sink idle", {7'd0, sinkValid}, 8'h00);
    check("R8 irq low", {7'd0, irqReq}, 8'h00);
    busRead(ADDR_CTRL, r); check("R8 status", r, 8'h02);
    sinkReady = 1'b1;
    repeat (3) @(negedge clk);

    // R9 asynchronous reset mid-operation
    busWrite(ADDR_CTRL, 8'hA0);
    sinkReady = 1'b0;
    busWrite(ADDR_DATA, 8'h66);
    #1 rstN = 1'b0;
    @(negedge clk);
    check("R9 async idle", {7'd0, sinkValid}, 8'h00);
    check("R9 async irq", {7'd0, irqReq}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    busRead(ADDR_CTRL, r); check("R9 async status", r, 8'h02);

    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R5: actual %0d left expected 0 left", expQ.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule